// File: doc/BRIEF.md
# Dual-Slope Phase Sequencer

This block is the timing controller of a switched-capacitor, noise-shaping dual-slope capacitance-to-digital converter. It runs on a fast clock and divides every converter cycle into four fast-clock slots. The slots are a comparator slot, a precharge/auto-zero slot, a dead slot and an integrate slot, in that order. From these slots it builds enables that never overlap for the precharge half and the integrate half of the switched-capacitor integrator. A conversion is N converter cycles of sensor integration followed by M converter cycles of digitization.

During digitization the sequencer strobes the comparator once per converter cycle. It turns each decision into a feedback DAC polarity that opposes the integrator's sign. Feedback does not stop at the first sign change. Nothing in the sequence ever clears the integrator, so the leftover quantization error carries into the next conversion. A counter outside the block sums the M single-bit decisions.

N and M are sampled from configuration inputs only when a conversion begins. While `run_i` stays high, conversions follow each other with no gap.

Top module: `dual_slope_seq`

## Requirements
- R1: While `rst_ni` is low, and on the first sample after it is released with `run_i` low, every output is 0.
- R2: A conversion with effective lengths N and M spends 4·N fast clocks with `phase1_o`=1, then 4·M fast clocks with `phase2_o`=1. The two flags are never high together, and both are 0 when idle.
- R3: In every active converter cycle, slot 0 has neither enable, slot 1 has only `pre_en_o`, slot 2 has neither enable, and slot 3 has only `int_en_o`. `pre_en_o` and `int_en_o` are never high in the same clock or in adjacent clocks.
- R4: `cmp_strobe_o` is high for exactly slot 0 of every Phase II converter cycle. It is never high in Phase I or when idle.
- R5: On each fast clock where `cmp_strobe_o` is high, `cmp_i` is captured, and from the next clock `dac_pos_o` equals its inverse. A `cmp_i` of 1 means the integrator is positive, and a `dac_pos_o` of 1 selects the positive reference. This happens on every strobe of Phase II, including after the decision changes sign. At all other times `dac_pos_o` holds its value, through Phase I and idle.
- R6: `conv_start_o` is a one-clock pulse on the first fast clock of each conversion, which is slot 0 of the first Phase I converter cycle.
- R7: `conv_done_o` is a one-clock pulse on the fast clock right after the last Phase II strobe, which is slot 1 of the last Phase II converter cycle.
- R8: `n_cfg_i` and `m_cfg_i` are sampled only at the clock edge that starts a conversion. Changes made during a conversion first take effect in the following conversion.
- R9: A configured N or M of 0 is treated as 1.
- R10: When idle, a conversion starts on the clock after `run_i` is seen high. `run_i` is sampled at the final clock of a conversion: if it is 1 the next conversion follows with no gap, and if it is 0 the block goes idle with all outputs except `dac_pos_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Keep converting while high |
| n_cfg_i | input | CNT_W | Phase I length in converter cycles |
| m_cfg_i | input | CNT_W | Phase II length in converter cycles |
| cmp_i | input | 1 | Comparator decision, 1 = integrator positive |
| phase1_o | output | 1 | Sensor integration phase active |
| phase2_o | output | 1 | Digitization phase active (DAC connected in place of the bridge) |
| pre_en_o | output | 1 | Precharge and amplifier auto-zero half enable |
| int_en_o | output | 1 | Integrate half enable |
| cmp_strobe_o | output | 1 | Comparator evaluation strobe |
| dac_pos_o | output | 1 | Feedback DAC precharge polarity, 1 = positive reference |
| conv_start_o | output | 1 | First clock of a conversion |
| conv_done_o | output | 1 | Clock after the last comparator strobe |

## Verification
The bench builds the block with the default CNT_W of 8 and programs N and M at runtime. It uses small lengths (1 to 6), so every slot of every converter cycle, including both phase boundaries, can be checked clock by clock. The runtime values cover several cases: zero values that clamp to one, and a configuration rewritten in the middle of a conversion in a back-to-back pair. The comparator patterns hold a sign for several cycles and then flip, to show that the feedback keeps following the decisions. A mid-conversion drop of `run_i` checks that the conversion finishes and then stops cleanly.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SENSE = 2'd1,
    PH_DIGIT = 2'd2
  } phase_e;

  localparam int unsigned SLOT_W = 2;
  localparam logic [SLOT_W-1:0] SLOT_STROBE = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_PRE    = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_GAP    = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_INT    = 2'd3;
endpackage

// File: rtl/dss_slot_gen.sv
module dss_slot_gen #(
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  localparam logic [SLOT_W-1:0] SlotLast = {SLOT_W{1'b1}};

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       slot_q <= '0;
    else if (active_i) slot_q <= slot_q + 1'b1;
    else               slot_q <= '0;
  end

  assign slot_o = slot_q;
  assign last_o = active_i && (slot_q == SlotLast);
endmodule

// File: rtl/dss_phase_ctrl.sv
module dss_phase_ctrl
  import dss_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] n_cfg_i,
  input  logic [CNT_W-1:0] m_cfg_i,
  input  logic             last_slot_i,
  output phase_e           phase_o,
  output logic             first_cyc_o,
  output logic             last_cyc_o
);
  localparam logic [CNT_W-1:0] One = CNT_W'(1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, n_q, m_q;
  logic [CNT_W-1:0] n_eff, m_eff, len_cur;
  logic             cyc_end;

  // zero length clamps to one cycle
  assign n_eff   = (n_cfg_i == '0) ? One : n_cfg_i;
  assign m_eff   = (m_cfg_i == '0) ? One : m_cfg_i;
  assign len_cur = (phase_q == PH_DIGIT) ? m_q : n_q;
  assign cyc_end = (cnt_q == len_cur - One);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      n_q     <= One;
      m_q     <= One;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (run_i) begin
            phase_q <= PH_SENSE;
            cnt_q   <= '0;
            n_q     <= n_eff;
            m_q     <= m_eff;
          end
        end
        PH_SENSE: begin
          if (last_slot_i) begin
            if (cyc_end) begin
              phase_q <= PH_DIGIT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + One;
            end
          end
        end
        PH_DIGIT: begin
          if (last_slot_i) begin
            if (cyc_end) begin
              cnt_q <= '0;
              if (run_i) begin
                phase_q <= PH_SENSE;
                n_q     <= n_eff;
                m_q     <= m_eff;
              end else begin
                phase_q <= PH_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + One;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign first_cyc_o = (cnt_q == '0);
  assign last_cyc_o  = cyc_end;
endmodule

// File: rtl/dss_dac_fb.sv
module dss_dac_fb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic cmp_i,
  output logic pol_o
);
  logic pol_q;

  // negative feedback: positive integrator -> negative reference
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pol_q <= 1'b0;
    else if (strobe_i) pol_q <= ~cmp_i;
  end

  assign pol_o = pol_q;
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] n_cfg_i,
  input  logic [CNT_W-1:0] m_cfg_i,
  input  logic             cmp_i,
  output logic             phase1_o,
  output logic             phase2_o,
  output logic             pre_en_o,
  output logic             int_en_o,
  output logic             cmp_strobe_o,
  output logic             dac_pos_o,
  output logic             conv_start_o,
  output logic             conv_done_o
);
  phase_e            phase;
  logic [SLOT_W-1:0] slot;
  logic              last_slot, first_cyc, last_cyc, active;

  assign active = (phase != PH_IDLE);

  dss_slot_gen #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .slot_o   (slot),
    .last_o   (last_slot)
  );

  dss_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .n_cfg_i     (n_cfg_i),
    .m_cfg_i     (m_cfg_i),
    .last_slot_i (last_slot),
    .phase_o     (phase),
    .first_cyc_o (first_cyc),
    .last_cyc_o  (last_cyc)
  );

  dss_dac_fb u_dac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cmp_strobe_o),
    .cmp_i    (cmp_i),
    .pol_o    (dac_pos_o)
  );

  // SLOT_GAP and slot 0 act as dead intervals around the two halves
  assign phase1_o     = (phase == PH_SENSE);
  assign phase2_o     = (phase == PH_DIGIT);
  assign pre_en_o     = active && (slot == SLOT_PRE);
  assign int_en_o     = active && (slot == SLOT_INT);
  assign cmp_strobe_o = phase2_o && (slot == SLOT_STROBE);
  assign conv_start_o = phase1_o && first_cyc && (slot == SLOT_STROBE);
  assign conv_done_o  = phase2_o && last_cyc && (slot == SLOT_PRE);
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmp_i,
  input logic phase1_o,
  input logic phase2_o,
  input logic pre_en_o,
  input logic int_en_o,
  input logic cmp_strobe_o,
  input logic dac_pos_o,
  input logic conv_start_o,
  input logic conv_done_o
);
  p_phase_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase1_o && phase2_o));

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pre_en_o && int_en_o));

  p_gap_after_pre_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_en_o |=> !int_en_o);

  p_gap_after_int_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_o |=> !pre_en_o);

  p_strobe_digit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_strobe_o |-> (phase2_o && !pre_en_o && !int_en_o));

  p_dac_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_strobe_o |=> (dac_pos_o == !$past(cmp_i)));

  p_dac_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_strobe_o |=> $stable(dac_pos_o));

  p_start_sense_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (phase1_o && !pre_en_o));

  p_done_after_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (phase2_o && pre_en_o && $past(cmp_strobe_o)));
endmodule

bind dual_slope_seq dual_slope_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmp_i        (cmp_i),
  .phase1_o     (phase1_o),
  .phase2_o     (phase2_o),
  .pre_en_o     (pre_en_o),
  .int_en_o     (int_en_o),
  .cmp_strobe_o (cmp_strobe_o),
  .dac_pos_o    (dac_pos_o),
  .conv_start_o (conv_start_o),
  .conv_done_o  (conv_done_o)
);

// File: tb/dual_slope_seq_tb_top.sv
module dual_slope_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             run_i = 1'b0;
  logic [CNT_W-1:0] n_cfg_i = '0;
  logic [CNT_W-1:0] m_cfg_i = '0;
  logic             cmp_i = 1'b0;
  logic phase1_o, phase2_o, pre_en_o, int_en_o, cmp_strobe_o;
  logic dac_pos_o, conv_start_o, conv_done_o;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  logic exp_dac = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_slope_seq #(.CNT_W(CNT_W)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .n_cfg_i      (n_cfg_i),
    .m_cfg_i      (m_cfg_i),
    .cmp_i        (cmp_i),
    .phase1_o     (phase1_o),
    .phase2_o     (phase2_o),
    .pre_en_o     (pre_en_o),
    .int_en_o     (int_en_o),
    .cmp_strobe_o (cmp_strobe_o),
    .dac_pos_o    (dac_pos_o),
    .conv_start_o (conv_start_o),
    .conv_done_o  (conv_done_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk_idle(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      chk(req, {1'b0, phase1_o, phase2_o, pre_en_o, int_en_o, cmp_strobe_o,
                conv_start_o, conv_done_o}, 8'h00);
      chk({req, " dac held R5"}, {7'b0, dac_pos_o}, {7'b0, exp_dac});
      step();
    end
  endtask

  // Called at the first clock of a conversion; walks it slot by slot.
  task automatic conv_check(input int n, input int m, input logic [63:0] pat);
    for (int c = 0; c < n + m; c++) begin
      for (int s = 0; s < 4; s++) begin
        logic p1, p2;
        p1 = (c < n);
        p2 = !p1;
        chk("R2 phase flags", {6'b0, phase1_o, phase2_o}, {6'b0, p1, p2});
        chk("R3 half enables", {6'b0, pre_en_o, int_en_o},
            {6'b0, logic'(s == 1), logic'(s == 3)});
        chk("R4 strobe", {7'b0, cmp_strobe_o}, {7'b0, logic'(p2 && s == 0)});
        chk("R6 start", {7'b0, conv_start_o}, {7'b0, logic'(c == 0 && s == 0)});
        chk("R7 done", {7'b0, conv_done_o},
            {7'b0, logic'(c == n + m - 1 && s == 1)});
        chk("R5 dac polarity", {7'b0, dac_pos_o}, {7'b0, exp_dac});
        if (p2 && s == 0) begin
          cmp_i = pat[c - n];
          step();
          exp_dac = ~pat[c - n];
        end else begin
          step();
        end
      end
    end
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) step();
    chk("R1 outputs in reset", {phase1_o, phase2_o, pre_en_o, int_en_o, cmp_strobe_o,
        dac_pos_o, conv_start_o, conv_done_o}, 8'h00);
    rst_ni = 1'b1;
    exp_dac = 1'b0;
    chk("R1 after release", {phase1_o, phase2_o, pre_en_o, int_en_o, cmp_strobe_o,
        dac_pos_o, conv_start_o, conv_done_o}, 8'h00);
    chk_idle("R10 idle with run low", 3);
  endtask

  task automatic test_basic();
    n_cfg_i = 8'd3;
    m_cfg_i = 8'd4;
    run_i   = 1'b1;
    step();
    run_i = 1'b0;  // R10: drop mid-conversion, conversion must finish
    conv_check(3, 4, 64'b0110);
    chk_idle("R10 idle after stop", 4);
  endtask

  task automatic test_sign_change();
    n_cfg_i = 8'd2;
    m_cfg_i = 8'd6;
    run_i   = 1'b1;
    step();
    run_i = 1'b0;
    // R5: three positive decisions then three negative, feedback follows all
    conv_check(2, 6, 64'b000111);
    chk_idle("R10 idle after sign test", 2);
  endtask

  task automatic test_cfg_midway();
    n_cfg_i = 8'd2;
    m_cfg_i = 8'd2;
    run_i   = 1'b1;
    step();
    n_cfg_i = 8'd5;  // R8: mid-conversion write, must not affect this one
    m_cfg_i = 8'd3;
    conv_check(2, 2, 64'b10);
    run_i = 1'b0;    // R10: back-to-back second conversion with new values
    conv_check(5, 3, 64'b011);
    chk_idle("R8 idle after reconfig", 2);
  endtask

  task automatic test_zero_len();
    n_cfg_i = 8'd0;
    m_cfg_i = 8'd0;
    run_i   = 1'b1;
    step();
    run_i = 1'b0;
    conv_check(1, 1, 64'b1);  // R9: zero lengths behave as one
    chk_idle("R9 idle after zero-length", 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2;
    test_reset();
    test_basic();
    test_sign_change();
    test_cfg_midway();
    test_zero_len();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule